// File: doc/BRIEF.md
# Serial Channel Connection-Mode Router

This block is the routing and clock-selection stage of one synchronous serial channel. It sits between the transmit shift register, the receive shift register, the external serial pins (receive data, transmit data and the transmit-clock pin) and an external clock-recovery stage. The clock-recovery stage is seen only as a recovered data bit, a recovered clock and a select bit that says whether the receiver uses them.

A 2-bit connection-mode request chooses one of four routings:

- normal full duplex;
- echo, where received data is sent straight back out and the local transmitter is disabled;
- local loopback, where the transmit shift register output feeds the receiver internally while the receive pin is still echoed out;
- a reserved code, which the block treats as full duplex and records in a sticky flag.

A new mode is applied only on a clock edge at which both shift registers report idle, so no character is cut in half by a routing change. All data and clock routing is combinational from the applied mode, so the paths add no latency.

Top module: `sercon_router`

## Requirements
- R1: After synchronous reset the applied mode is 00 (full duplex) and the illegal-mode flag is 0.
- R2: The applied mode takes the value of `mode_req` at a rising clock edge only when `tx_idle` and `rx_idle` are both 1 at that edge. At any other edge the applied mode holds its value.
- R3: In mode 00, `txd_pin` follows `tsr_out`. The receive shift register input `rsr_in` follows the selected receive data, which is `recov_data` when `recov_sel`=1 and `rxd_pin` otherwise. `rx_clk` follows the selected receive clock, which is `recov_clk` when `recov_sel`=1 and `rxc_pin` otherwise. `tx_clk` is `tx_clk_src` when `txc_is_out`=1 and `txc_pin_in` otherwise. `txc_pin_out` is `tx_clk_src` when `txc_is_out`=1 and 0 otherwise.
- R4: In every mode `txc_pin_oe` equals `txc_is_out`.
- R5: In mode 01 (echo), `txd_pin` carries the selected receive data and `rsr_in` carries the same data. `rx_clk` and `tx_clk` both carry the selected receive clock.
- R6: In modes 01 and 11, `txc_pin_out` carries the selected receive clock when `txc_is_out`=1 and is 0 otherwise. In these modes `txc_pin_in` has no effect on any output.
- R7: In mode 11 (loopback), `rsr_in` follows `tsr_out` whatever the value of `recov_sel`. `rx_clk` and `tx_clk` both carry the selected receive clock. `txd_pin` carries the selected receive data.
- R8: Mode 10 routes exactly as mode 00. The illegal-mode flag is set at the edge where code 10 is applied and stays 1 until reset. A code 10 request that is held off by R2 does not set the flag.
- R9: `tx_enable` is 0 while the applied mode is 01 and 1 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested connection mode |
| tx_idle | input | 1 | Transmit shift register is idle |
| rx_idle | input | 1 | Receive shift register is idle |
| recov_sel | input | 1 | Receiver uses recovered data and clock |
| rxd_pin | input | 1 | Receive data pin |
| rxc_pin | input | 1 | External receive clock |
| recov_data | input | 1 | Data from clock recovery |
| recov_clk | input | 1 | Clock from clock recovery |
| tx_clk_src | input | 1 | Internally selected transmit clock |
| txc_is_out | input | 1 | Transmit-clock pin configured as output |
| txc_pin_in | input | 1 | Transmit-clock pin input value |
| tsr_out | input | 1 | Transmit shift register serial output |
| txd_pin | output | 1 | Transmit data pin |
| txc_pin_out | output | 1 | Transmit-clock pin output value |
| txc_pin_oe | output | 1 | Transmit-clock pin output enable |
| rsr_in | output | 1 | Receive shift register serial input |
| rx_clk | output | 1 | Clock to receiver |
| tx_clk | output | 1 | Clock to transmitter |
| tx_enable | output | 1 | Transmitter may start a frame |
| active_mode | output | 2 | Currently applied mode |
| illegal_mode | output | 1 | Sticky reserved-code flag |

## Verification
The only state in the block is the applied mode register and the sticky flag. A wrong value in either shows at the ports in the cycle right after the faulty edge: `active_mode` reads back wrong, and every routed pin follows the wrong source for as long as the bad state lasts. An early or late mode update, for example one taken while a shift register is busy, shows up one edge after a busy-phase request. The full sweep of every data and clock input combination in each mode catches any crossed route within one vector.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    typedef enum logic [1:0] {
        CONN_DUPLEX = 2'b00,
        CONN_ECHO   = 2'b01,
        CONN_RSVD   = 2'b10,
        CONN_LOOP   = 2'b11
    } conn_mode_e;

    typedef struct packed {
        logic data;
        logic clk;
    } ser_pair_t;

    typedef struct packed {
        logic txd;
        logic rsr;
        logic tx_en;
    } data_route_t;

    typedef struct packed {
        logic rx_clk;
        logic tx_clk;
        logic txc_out;
    } clk_route_t;

    // Source for the receive side: recovered pair or raw pins.
    function automatic ser_pair_t pick_rx_source(logic use_recov,
                                                 ser_pair_t pin_pair,
                                                 ser_pair_t rec_pair);
        return use_recov ? rec_pair : pin_pair;
    endfunction

    // The reserved code routes as full duplex.
    function automatic conn_mode_e route_mode(conn_mode_e m);
        return (m == CONN_RSVD) ? CONN_DUPLEX : m;
    endfunction

    // Modes that send received data back out and reuse the receive clock.
    function automatic logic echo_like(conn_mode_e m);
        return (m == CONN_ECHO) || (m == CONN_LOOP);
    endfunction

endpackage

// File: rtl/sercon_mode_ctl.sv
module sercon_mode_ctl
    import sercon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       tx_idle,
    input  logic       rx_idle,
    output conn_mode_e mode_q,
    output logic       illegal_q
);

    logic both_idle;
    assign both_idle = tx_idle & rx_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= CONN_DUPLEX;
            illegal_q <= 1'b0;
        end else if (both_idle) begin
            mode_q <= conn_mode_e'(mode_req);
            if (conn_mode_e'(mode_req) == CONN_RSVD) begin
                illegal_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sercon_clk_route.sv
module sercon_clk_route
    import sercon_pkg::*;
(
    input  conn_mode_e mode,
    input  logic       sel_rx_clk,
    input  logic       tx_clk_src,
    input  logic       txc_is_out,
    input  logic       txc_pin_in,
    output clk_route_t route
);

    always_comb begin
        route.rx_clk = sel_rx_clk;
        if (echo_like(mode)) begin
            route.tx_clk  = sel_rx_clk;
            route.txc_out = txc_is_out & sel_rx_clk;
        end else begin
            route.tx_clk  = txc_is_out ? tx_clk_src : txc_pin_in;
            route.txc_out = txc_is_out & tx_clk_src;
        end
    end

endmodule

// File: rtl/sercon_data_route.sv
module sercon_data_route
    import sercon_pkg::*;
(
    input  conn_mode_e  mode,
    input  logic        sel_rx_data,
    input  logic        tsr_out,
    output data_route_t route
);

    always_comb begin
        route.tx_en = 1'b1;
        unique case (mode)
            CONN_ECHO: begin
                route.txd   = sel_rx_data;
                route.rsr   = sel_rx_data;
                route.tx_en = 1'b0;
            end
            CONN_LOOP: begin
                route.txd = sel_rx_data;
                route.rsr = tsr_out;
            end
            default: begin
                route.txd = tsr_out;
                route.rsr = sel_rx_data;
            end
        endcase
    end

endmodule

// File: rtl/sercon_router.sv
module sercon_router
    import sercon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       tx_idle,
    input  logic       rx_idle,
    input  logic       recov_sel,
    input  logic       rxd_pin,
    input  logic       rxc_pin,
    input  logic       recov_data,
    input  logic       recov_clk,
    input  logic       tx_clk_src,
    input  logic       txc_is_out,
    input  logic       txc_pin_in,
    input  logic       tsr_out,
    output logic       txd_pin,
    output logic       txc_pin_out,
    output logic       txc_pin_oe,
    output logic       rsr_in,
    output logic       rx_clk,
    output logic       tx_clk,
    output logic       tx_enable,
    output logic [1:0] active_mode,
    output logic       illegal_mode
);

    conn_mode_e  mode_q;
    conn_mode_e  eff_mode;
    ser_pair_t   pin_pair;
    ser_pair_t   rec_pair;
    ser_pair_t   rx_src;
    data_route_t d_route;
    clk_route_t  c_route;

    sercon_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_req  (mode_req),
        .tx_idle   (tx_idle),
        .rx_idle   (rx_idle),
        .mode_q    (mode_q),
        .illegal_q (illegal_mode)
    );

    assign eff_mode = route_mode(mode_q);
    assign pin_pair = '{data: rxd_pin, clk: rxc_pin};
    assign rec_pair = '{data: recov_data, clk: recov_clk};
    assign rx_src   = pick_rx_source(recov_sel, pin_pair, rec_pair);

    sercon_data_route u_data (
        .mode        (eff_mode),
        .sel_rx_data (rx_src.data),
        .tsr_out     (tsr_out),
        .route       (d_route)
    );

    sercon_clk_route u_clk (
        .mode       (eff_mode),
        .sel_rx_clk (rx_src.clk),
        .tx_clk_src (tx_clk_src),
        .txc_is_out (txc_is_out),
        .txc_pin_in (txc_pin_in),
        .route      (c_route)
    );

    assign txd_pin     = d_route.txd;
    assign rsr_in      = d_route.rsr;
    assign tx_enable   = d_route.tx_en;
    assign rx_clk      = c_route.rx_clk;
    assign tx_clk      = c_route.tx_clk;
    assign txc_pin_out = c_route.txc_out;
    assign txc_pin_oe  = txc_is_out;
    assign active_mode = mode_q;

endmodule

// File: rtl/sercon_router_chk.sv
module sercon_router_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_req,
    input logic       tx_idle,
    input logic       rx_idle,
    input logic       recov_sel,
    input logic       recov_data,
    input logic       tsr_out,
    input logic       txd_pin,
    input logic       rsr_in,
    input logic       tx_enable,
    input logic [1:0] active_mode,
    input logic       illegal_mode
);

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(tx_idle && rx_idle) |=> $stable(active_mode)); // R2

    AST_MODE_APPLIED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (tx_idle && rx_idle) |=> (active_mode == $past(mode_req))); // R2

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        illegal_mode |=> illegal_mode); // R8

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b10) |-> illegal_mode); // R8

    AST_ECHO_NO_TX: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b01) |-> !tx_enable); // R9

    AST_LOOP_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        (active_mode == 2'b11) |-> (rsr_in == tsr_out)); // R7

    AST_ECHO_RECOVERED: assert property (@(posedge clk) disable iff (rst)
        (active_mode[0] && recov_sel) |-> (txd_pin == recov_data)); // R5

endmodule

bind sercon_router sercon_router_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_req     (mode_req),
    .tx_idle      (tx_idle),
    .rx_idle      (rx_idle),
    .recov_sel    (recov_sel),
    .recov_data   (recov_data),
    .tsr_out      (tsr_out),
    .txd_pin      (txd_pin),
    .rsr_in       (rsr_in),
    .tx_enable    (tx_enable),
    .active_mode  (active_mode),
    .illegal_mode (illegal_mode)
);

// File: tb/sercon_router_bench.sv
module sercon_router_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic [1:0] mode_req;
    logic       tx_idle, rx_idle;
    logic       recov_sel, rxd_pin, rxc_pin, recov_data, recov_clk;
    logic       tx_clk_src, txc_is_out, txc_pin_in, tsr_out;
    logic       txd_pin, txc_pin_out, txc_pin_oe, rsr_in, rx_clk, tx_clk, tx_enable;
    logic [1:0] active_mode;
    logic       illegal_mode;

    int n_cmp = 0;
    int n_bad = 0;

    sercon_router u_sercon_router (
        .clk(clk), .rst(rst), .mode_req(mode_req),
        .tx_idle(tx_idle), .rx_idle(rx_idle), .recov_sel(recov_sel),
        .rxd_pin(rxd_pin), .rxc_pin(rxc_pin), .recov_data(recov_data),
        .recov_clk(recov_clk), .tx_clk_src(tx_clk_src), .txc_is_out(txc_is_out),
        .txc_pin_in(txc_pin_in), .tsr_out(tsr_out), .txd_pin(txd_pin),
        .txc_pin_out(txc_pin_out), .txc_pin_oe(txc_pin_oe), .rsr_in(rsr_in),
        .rx_clk(rx_clk), .tx_clk(tx_clk), .tx_enable(tx_enable),
        .active_mode(active_mode), .illegal_mode(illegal_mode)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // v bits: 0 rxd, 1 recov_data, 2 rxc, 3 recov_clk, 4 tx_clk_src,
    //         5 txc_pin_in, 6 tsr_out, 7 txc_is_out, 8 recov_sel
    task automatic apply(logic [8:0] v);
        rxd_pin    = v[0];
        recov_data = v[1];
        rxc_pin    = v[2];
        recov_clk  = v[3];
        tx_clk_src = v[4];
        txc_pin_in = v[5];
        tsr_out    = v[6];
        txc_is_out = v[7];
        recov_sel  = v[8];
    endtask

    // Expected {txd, rsr, rx_clk, tx_clk, txc_out, txc_oe, tx_en}
    function automatic logic [6:0] expect_out(int m, logic [8:0] v);
        logic rdat, rclk, echo, out;
        logic txd, rsr, txclk, txcout;
        rdat   = v[8] ? v[1] : v[0];
        rclk   = v[8] ? v[3] : v[2];
        out    = v[7];
        echo   = (m == 1) || (m == 3);
        txd    = echo ? rdat : v[6];
        rsr    = (m == 3) ? v[6] : rdat;
        txclk  = echo ? rclk : (out ? v[4] : v[5]);
        txcout = out ? (echo ? rclk : v[4]) : 1'b0;
        return {txd, rsr, rclk, txclk, txcout, out, (m != 1)};
    endfunction

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_req = m;
        tx_idle  = 1'b1;
        rx_idle  = 1'b1;
        @(negedge clk);
        check("R2 mode applied when idle", 32'(active_mode), 32'(m));
    endtask

    task automatic sweep(int m, string req);
        for (int v = 0; v < 512; v++) begin
            @(negedge clk);
            apply(9'(v));
            #1;
            check(req, 32'({txd_pin, rsr_in, rx_clk, tx_clk, txc_pin_out,
                            txc_pin_oe, tx_enable}),
                  32'(expect_out(m, 9'(v))));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_req = 2'b00; tx_idle = 1'b1; rx_idle = 1'b1;
        apply(9'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset mode", 32'(active_mode), 32'd0);
        check("R1 reset flag", 32'(illegal_mode), 32'd0);

        // R2: request loopback while busy, then release idles one at a time
        @(negedge clk);
        tx_idle = 1'b0; mode_req = 2'b11;
        repeat (3) @(negedge clk);
        check("R2 held while tx busy", 32'(active_mode), 32'd0);
        tx_idle = 1'b1; rx_idle = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 held while rx busy", 32'(active_mode), 32'd0);
        rx_idle = 1'b1;
        @(negedge clk);
        check("R2 applied once both idle", 32'(active_mode), 32'd3);
        apply(9'b0_0100_0000);
        #1;
        check("R7 loop feeds receiver", 32'(rsr_in), 32'd1);

        set_mode(2'b00);
        sweep(0, "R3 R4 R9 duplex routing");
        set_mode(2'b01);
        sweep(1, "R5 R4 R6 R9 echo routing");
        set_mode(2'b11);
        sweep(3, "R7 R4 R6 R9 loopback routing");
        check("R8 flag clear for legal modes", 32'(illegal_mode), 32'd0);

        // R8: reserved code held off while busy must not set the flag
        set_mode(2'b00);
        @(negedge clk);
        rx_idle = 1'b0; mode_req = 2'b10;
        repeat (2) @(negedge clk);
        check("R8 busy reserved flag", 32'(illegal_mode), 32'd0);
        check("R2 busy reserved mode", 32'(active_mode), 32'd0);

        set_mode(2'b10);
        check("R8 flag set", 32'(illegal_mode), 32'd1);
        sweep(2, "R8 R4 R9 reserved as duplex");
        set_mode(2'b00);
        check("R8 flag sticky", 32'(illegal_mode), 32'd1);
        set_mode(2'b01);
        check("R8 flag sticky echo", 32'(illegal_mode), 32'd1);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset clears flag", 32'(illegal_mode), 32'd0);
        check("R1 reset mode again", 32'(active_mode), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule